// File: doc/BRIEF.md
# Configuration Power-On Reset Sequencer

This block brings a programmable device from power-up to user mode. After the power-on reset is released it waits for a fixed delay. A select input picks a long or a short delay. For that whole delay it pulls a shared open-drain status line low. A partner device on the same line can hold the pair back in the same way: the line reads high only when neither side pulls it down, as though a resistor pulled it up.

After the delay the block sits in a reset stage until the configuration request input rises. It then stops pulling the line and waits until it senses the line high before it declares itself ready for data. A done input marks the end of data loading. A fixed number of initialization cycles follows, and after that the user I/O leave tri-state.

If the request drops during loading or initialization, the sequence falls back to reset. Weak pull-ups on the user I/O are offered during configuration unless a disable input is high. Delay lengths are parameters given in clock cycles.

Top module: `cfg_por_seq`

## Requirements
- R1: After reset release, the block stays in the power-on stage for exactly LONG_CYC clock cycles when `por_short_i` is 0 and SHORT_CYC cycles when it is 1. An early configuration request does not shorten this delay.
- R2: Throughout the power-on stage, `stat_pull_o` is 1, meaning the block drives the shared line low.
- R3: After the power-on stage, the block stays in the reset stage with `stat_pull_o` = 1 while the synchronized request is low. It leaves reset on a rising edge of the request. The request level before power-up counts as low, so a request that is already high when the power-on stage ends also starts the cycle.
- R4: On leaving reset the block sets `stat_pull_o` to 0 and waits. It enters the configuration stage only after it samples `stat_i` high through its synchronizer. While the partner holds the line low, it keeps waiting.
- R5: If the request goes low in the wait, configuration or initialization stage, the block returns to reset and pulls the line low again. A new rising edge is then needed to restart.
- R6: `load_done_i` high in the configuration stage moves the block to initialization on the next edge. The block stays there for exactly INIT_CYC cycles and then enters user mode, where it remains.
- R7: `io_tristate_o` is 1 in every stage except user mode, where it is 0.
- R8: `io_weak_pu_o` is 1 in the reset, wait, configuration and initialization stages when `pu_off_i` is 0. It is 0 in the power-on stage, in user mode, and whenever `pu_off_i` is 1.
- R9: `stage_o` reports the stage with this encoding: power-on = 0, reset = 1, wait-for-line = 2, configuration = 3, initialization = 4, user = 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| por_short_i | input | 1 | Delay select: 1 selects the short power-on delay |
| cfg_req_i | input | 1 | Configuration request, asynchronous; rising edge starts the cycle |
| stat_i | input | 1 | Sensed level of the shared open-drain status line |
| load_done_i | input | 1 | End of configuration data loading |
| pu_off_i | input | 1 | 1 disables the weak pull-ups on the user I/O |
| stat_pull_o | output | 1 | 1 drives the shared status line low; 0 releases it |
| io_tristate_o | output | 1 | Tri-state enable for the user I/O |
| io_weak_pu_o | output | 1 | Weak pull-up enable for the user I/O |
| stage_o | output | 3 | Current stage code |

## Verification
On every cycle, the assertions check the legal entries into each stage: the power-on stage is left only when the timer ends, reset is left only with the request high, configuration is entered only from the wait stage with the line sensed high, and user mode is entered only at the last initialization cycle. They also check that a dropped request always forces reset and that pull-ups never appear without tri-state. Only the bench scenarios can show the exact delay lengths for both select values, the partner holding the handshake, a request that is already high during the power-on stage, and the restart after an abort.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_RESET  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_CONFIG = 3'd3,
    ST_INIT   = 3'd4,
    ST_USER   = 3'd5
  } stage_e;

  // Length of the power-on delay for a given select level.
  function automatic int unsigned por_len(input logic short_sel,
                                          input int unsigned long_cyc,
                                          input int unsigned short_cyc);
    return short_sel ? short_cyc : long_cyc;
  endfunction

  // The block pulls the shared line low only before it leaves reset.
  function automatic logic line_pulled(input stage_e st);
    return (st == ST_POR) || (st == ST_RESET);
  endfunction

  function automatic logic weak_pu_on(input stage_e st, input logic pu_off);
    return !pu_off && ((st == ST_RESET) || (st == ST_WAIT) ||
                       (st == ST_CONFIG) || (st == ST_INIT));
  endfunction

endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
  parameter int W     = 2,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/cfgseq_por_timer.sv
module cfgseq_por_timer
  import cfgseq_pkg::*;
#(
  parameter int unsigned LONG_CYC  = 25000000,
  parameter int unsigned SHORT_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic short_sel_i,
  output logic done_o
);
  localparam int unsigned MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_w;

  assign last_w = CW'(por_len(short_sel_i, LONG_CYC, SHORT_CYC) - 1);
  assign done_o = (cnt_q >= last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (run_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  // R1
  por_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAXC - 1));
endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
  import cfgseq_pkg::*;
#(
  parameter int unsigned INIT_CYC = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   por_done_i,
  input  logic   req_hi_i,
  input  logic   stat_hi_i,
  input  logic   load_done_i,
  output stage_e state_o
);
  localparam int unsigned ICW = $clog2(INIT_CYC + 1);

  stage_e   state_q, state_d;
  logic     req_prev_q;
  logic     pend_q;
  logic [ICW-1:0] init_cnt_q;

  logic req_rise_w;
  logic go_w;
  logic init_last_w;

  assign req_rise_w  = req_hi_i && !req_prev_q;
  assign go_w        = pend_q || req_rise_w;
  assign init_last_w = (init_cnt_q == ICW'(INIT_CYC - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_POR:    if (por_done_i) state_d = ST_RESET;
      ST_RESET:  if (go_w) state_d = ST_WAIT;
      ST_WAIT:   if (!req_hi_i) state_d = ST_RESET;
                 else if (stat_hi_i) state_d = ST_CONFIG;
      ST_CONFIG: if (!req_hi_i) state_d = ST_RESET;
                 else if (load_done_i) state_d = ST_INIT;
      ST_INIT:   if (!req_hi_i) state_d = ST_RESET;
                 else if (init_last_w) state_d = ST_USER;
      ST_USER:   state_d = ST_USER;
      default:   state_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_POR;
      req_prev_q <= 1'b0;
      pend_q     <= 1'b0;
      init_cnt_q <= '0;
    end else begin
      state_q    <= state_d;
      req_prev_q <= req_hi_i;
      if (!req_hi_i)                       pend_q <= 1'b0;
      else if (state_q == ST_RESET && go_w) pend_q <= 1'b0;
      else if (req_rise_w)                 pend_q <= 1'b1;
      if (state_q == ST_INIT) init_cnt_q <= init_cnt_q + 1'b1;
      else                    init_cnt_q <= '0;
    end
  end

  assign state_o = state_q;

  // R1
  por_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_POR && $past(state_q) == ST_POR) |-> $past(por_done_i));

  // R3
  wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && $past(state_q) == ST_RESET) |-> $past(req_hi_i));

  // R4
  cfg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONFIG && $past(state_q) != ST_CONFIG) |->
      ($past(state_q) == ST_WAIT && $past(stat_hi_i)));

  // R5
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(state_q) == ST_WAIT || $past(state_q) == ST_CONFIG ||
      $past(state_q) == ST_INIT) && !$past(req_hi_i)) |-> state_q == ST_RESET);

  // R6
  user_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_USER && $past(state_q) != ST_USER) |->
      ($past(state_q) == ST_INIT && $past(init_last_w)));
endmodule

// File: rtl/cfg_por_seq.sv
module cfg_por_seq
  import cfgseq_pkg::*;
#(
  parameter int unsigned LONG_CYC  = 25000000,
  parameter int unsigned SHORT_CYC = 500000,
  parameter int unsigned INIT_CYC  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_short_i,
  input  logic       cfg_req_i,
  input  logic       stat_i,
  input  logic       load_done_i,
  input  logic       pu_off_i,
  output logic       stat_pull_o,
  output logic       io_tristate_o,
  output logic       io_weak_pu_o,
  output logic [2:0] stage_o
);
  logic [1:0] sync_w;
  logic       req_hi_w;
  logic       stat_hi_w;
  logic       por_done_w;
  stage_e     state_w;

  cfgseq_sync #(.W(2), .DEPTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cfg_req_i, stat_i}),
    .q_o   (sync_w)
  );
  assign req_hi_w  = sync_w[1];
  assign stat_hi_w = sync_w[0];

  cfgseq_por_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (state_w == ST_POR),
    .short_sel_i (por_short_i),
    .done_o      (por_done_w)
  );

  cfgseq_fsm #(.INIT_CYC(INIT_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_done_i  (por_done_w),
    .req_hi_i    (req_hi_w),
    .stat_hi_i   (stat_hi_w),
    .load_done_i (load_done_i),
    .state_o     (state_w)
  );

  assign stat_pull_o   = line_pulled(state_w);
  assign io_tristate_o = (state_w != ST_USER);
  assign io_weak_pu_o  = weak_pu_on(state_w, pu_off_i);
  assign stage_o       = state_w;

  // R8
  pu_needs_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_weak_pu_o |-> io_tristate_o);

  // R2
  por_holds_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_o == 3'd0) |-> stat_pull_o);
endmodule

// File: tb/tb_cfg_por_seq.sv
module tb_cfg_por_seq;
  localparam int LONG  = 40;
  localparam int SHORT = 12;
  localparam int INIT  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_short = 1'b0;
  logic cfg_req = 1'b0;
  logic partner_low = 1'b0;
  logic load_done = 1'b0;
  logic pu_off = 1'b0;
  logic stat_pull, io_tri, io_pu;
  logic [2:0] stage;
  logic stat_line;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  // wired-AND of both parties on the shared line
  assign stat_line = !(stat_pull || partner_low);

  cfg_por_seq #(.LONG_CYC(LONG), .SHORT_CYC(SHORT), .INIT_CYC(INIT)) dut (
    .clk(clk), .rst_n(rst_n), .por_short_i(por_short), .cfg_req_i(cfg_req),
    .stat_i(stat_line), .load_done_i(load_done), .pu_off_i(pu_off),
    .stat_pull_o(stat_pull), .io_tristate_o(io_tri), .io_weak_pu_o(io_pu),
    .stage_o(stage)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_stage(input int target, input int max_cyc, input string req);
    int seen = 0;
    for (int i = 0; i < max_cyc; i++) begin
      if (int'(stage) == target) begin
        seen = 1;
        break;
      end
      tick(1);
    end
    if (int'(stage) == target) seen = 1;
    check(req, int'(stage), target);
  endtask

  task automatic do_reset(input logic sel, input logic pdis);
    rst_n = 1'b0; cfg_req = 1'b0; partner_low = 1'b0; load_done = 1'b0;
    pu_off = pdis; por_short = sel;
    tick(2);
    check("R9 reset stage", int'(stage), 0);
    check("R2 reset pull", int'(stat_pull), 1);
    check("R7 reset tri", int'(io_tri), 1);
    check("R8 reset pu", int'(io_pu), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_por_long();
    do_reset(1'b0, 1'b0);
    tick(LONG - 1);
    check("R1 long still por", int'(stage), 0);
    check("R2 long pull", int'(stat_pull), 1);
    check("R8 por pu off", int'(io_pu), 0);
    tick(1);
    check("R1 long exit", int'(stage), 1);
    check("R3 reset pull", int'(stat_pull), 1);
    check("R8 reset pu on", int'(io_pu), 1);
    check("R7 reset tri", int'(io_tri), 1);
  endtask

  task automatic t_handshake();
    tick(20);
    check("R3 held in reset", int'(stage), 1);
    check("R3 reset pull", int'(stat_pull), 1);
    partner_low = 1'b1;
    cfg_req = 1'b1;
    wait_stage(2, 8, "R3 leave reset");
    check("R4 line released", int'(stat_pull), 0);
    tick(30);
    check("R4 partner holds", int'(stage), 2);
    check("R8 wait pu", int'(io_pu), 1);
    partner_low = 1'b0;
    wait_stage(3, 8, "R4 enter config");
    check("R7 config tri", int'(io_tri), 1);
  endtask

  task automatic t_abort_cfg();
    cfg_req = 1'b0;
    wait_stage(1, 5, "R5 abort to reset");
    check("R5 abort pull", int'(stat_pull), 1);
    tick(20);
    check("R5 stays reset", int'(stage), 1);
    cfg_req = 1'b1;
    wait_stage(3, 12, "R5 restart config");
  endtask

  task automatic t_done();
    load_done = 1'b1;
    tick(1);
    load_done = 1'b0;
    check("R6 enter init", int'(stage), 4);
    tick(INIT - 1);
    check("R6 init length", int'(stage), 4);
    check("R7 init tri", int'(io_tri), 1);
    tick(1);
    check("R6 enter user", int'(stage), 5);
    check("R7 user tri", int'(io_tri), 0);
    check("R8 user pu", int'(io_pu), 0);
    tick(10);
    check("R6 user stays", int'(stage), 5);
  endtask

  task automatic t_por_short();
    do_reset(1'b1, 1'b0);
    tick(SHORT - 1);
    check("R1 short still por", int'(stage), 0);
    tick(1);
    check("R1 short exit", int'(stage), 1);
  endtask

  task automatic t_abort_init();
    cfg_req = 1'b1;
    wait_stage(3, 12, "R4 config again");
    load_done = 1'b1;
    tick(1);
    load_done = 1'b0;
    tick(1);
    check("R6 in init", int'(stage), 4);
    cfg_req = 1'b0;
    wait_stage(1, 5, "R5 init abort");
    check("R5 init abort pull", int'(stat_pull), 1);
  endtask

  task automatic t_pu_disable();
    do_reset(1'b1, 1'b1);
    tick(SHORT);
    check("R8 disabled in reset", int'(io_pu), 0);
    cfg_req = 1'b1;
    wait_stage(3, 12, "R4 config pu off");
    check("R8 disabled in config", int'(io_pu), 0);
    check("R7 config tri", int'(io_tri), 1);
  endtask

  task automatic t_req_early();
    do_reset(1'b1, 1'b0);
    cfg_req = 1'b1;
    tick(SHORT - 1);
    check("R1 early req no shortcut", int'(stage), 0);
    wait_stage(3, 12, "R3 early request starts");
  endtask

  initial begin
    t_por_long();
    t_handshake();
    t_abort_cfg();
    t_done();
    t_por_short();
    t_abort_init();
    t_pu_disable();
    t_req_early();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule